// File: doc/BRIEF.md
# Compare-Match Timer Interrupt Path

This block counts up with an 8-bit counter and compares the count against a programmable compare value. When they are equal while the counter runs, a match event occurs. The event travels through two interrupt stages. The first is a peripheral-local stage with its own flag and enable. The second is a single interrupt-controller channel with its own flag, its own enable and a 3-bit priority level. The channel presents a request line and the level to a processor core.

Software reaches all state through a small register port. A write strobe, an address and a data byte perform writes. Read data is a combinational mux of the addressed register.

Register map, by address:

- 0 holds the run bit in bit 0.
- 1 returns the current count. It is read-only, and writes to it are ignored.
- 2 holds the compare value.
- 3 is the local stage: flag in bit 0, written 1 to clear, and enable in bit 1.
- 4 is the channel: flag in bit 0, written 1 to clear; enable in bit 1; level in bits 4:2; and a read-only trigger-mode bit in bit 5.
- Addresses 5 to 7 read as 0.

Top module: `cmp_irq_timer`

## Requirements
- R1: After reset every register reads 0, except the channel register, which reads 0x20. The count advances by one per clock only while the run bit is 1, and it holds while the run bit is 0.
- R2: A match event occurs on a clock edge where the run bit is 1 and the count equals the compare value. At that edge the count returns to 0, so with compare value C a running counter repeats every C+1 cycles.
- R3: A match event sets the local flag (address 3, bit 0) only if the local enable (address 3, bit 1) is 1. With the enable at 0 the flag stays 0 through any number of matches.
- R4: Writing 1 to address 3 bit 0 clears the local flag, and writing 0 there leaves it unchanged. A match and a clear on the same edge leave the flag at 1.
- R5: The local request equals the local flag. The channel flag (address 4, bit 0) becomes 1 on the edge after the local request rises, whatever the channel enable holds.
- R6: Writing 1 to address 4 bit 0 clears the channel flag, and writing 0 leaves it unchanged. A clear on the same edge as a request rise leaves it at 1. The flag does not set again while the local request stays high.
- R7: irq_req is 1 exactly when both the channel flag and the channel enable (address 4, bit 1) are 1. irq_level always shows the level field (address 4, bits 4:2).
- R8: Address 4 bit 5 always reads 1, and writes to it have no effect.
- R9: While the counter is stopped with the count equal to the compare value, no match event occurs and the local flag stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register, combinational |
| irq_req | output | 1 | Interrupt request to the core |
| irq_level | output | 3 | Priority level presented with the request |

## Verification
A register write takes effect at the clock edge that samples the strobe. A running counter shows each increment one edge later, and a match sets the local flag at the same edge where the count wraps. The channel flag follows one edge after that, and irq_req, irq_level and rdata follow the registers combinationally. Every driver step starts just after a rising edge and lasts exactly one clock, and the monitor compares at the falling edge within that step. The expected values therefore come from counting driver steps between the run-bit write and each check, with each step's edge assigned its count, flag or channel update. The same-edge cases (set against clear on either flag) are staged by placing a write exactly on the edge that produces a match or a request rise.

// File: rtl/cmpirq_pkg.sv
// Package: register addresses and field positions shared by the timer
// interrupt path and its testbench. Assumes a 3-bit register address.
package cmpirq_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_RUN   = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP   = 3'd2;
    localparam logic [ADDR_W-1:0] A_LOCAL = 3'd3;
    localparam logic [ADDR_W-1:0] A_CHAN  = 3'd4;

    localparam int LOC_FLAG_BIT = 0;
    localparam int LOC_EN_BIT   = 1;
    localparam int CH_FLAG_BIT  = 0;
    localparam int CH_EN_BIT    = 1;
    localparam int CH_LVL_LO    = 2;
endpackage

// File: rtl/match_counter.sv
// Up-counter with compare. While run is high it advances once per clock.
// On an edge where it equals the compare value it returns to 0 and reports a
// match event for that cycle. A stopped counter never reports a match.
// Assumes: synchronous active-low reset.
module match_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] count,
    output logic         match_evt
);
    logic [W-1:0] cnt_q;
    logic         equal;

    // Equality between the count and the compare value.
    assign equal     = (cnt_q == cmp_val);
    // A match event exists only in a running cycle.
    assign match_evt = run && equal;
    assign count     = cnt_q;

    // Count register: hold when stopped, wrap to zero on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            if (equal) cnt_q <= '0;
            else       cnt_q <= cnt_q + W'(1);
        end
    end

    a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));
    a_r2_wrap_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> (cnt_q == '0));
endmodule

// File: rtl/local_irq_stage.sv
// Peripheral-local interrupt stage: an enable and a flag. A match sets the
// flag only when enabled. Writing 1 clears the flag, and a set on the same
// edge wins. The request line mirrors the flag.
// Assumes: the enable and the clear strobe arrive already decoded.
module local_irq_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic match_evt,
    input  logic cfg_wr,
    input  logic en_val,
    input  logic flag_clr,
    output logic flag,
    output logic en,
    output logic req
);
    logic flag_q;
    logic en_q;

    // Enable register, loaded on a write to the local register.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (cfg_wr) en_q <= en_val;
    end

    // Flag register: an enabled match sets it, and a write of 1 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (match_evt && en_q) flag_q <= 1'b1;
        else if (flag_clr)         flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign en   = en_q;
    assign req  = flag_q;

    a_r3_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !flag_q) |=> !flag_q);
    a_r4_kept_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/ctrl_irq_channel.sv
// One interrupt-controller channel. The rising edge of the incoming request
// latches the channel flag, whatever the enable holds. The flag is cleared by
// writing 1, and a set on the same edge wins. The core sees a request only
// when the flag and the enable are both set. The level is shown at all times.
// Assumes: req_in is synchronous to clk.
module ctrl_irq_channel #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    input  logic             cfg_wr,
    input  logic             en_val,
    input  logic [LVL_W-1:0] lvl_val,
    input  logic             flag_clr,
    output logic             flag,
    output logic             en,
    output logic [LVL_W-1:0] level,
    output logic             irq_req,
    output logic [LVL_W-1:0] irq_level
);
    logic             req_prev_q;
    logic             rise;
    logic             flag_q;
    logic             en_q;
    logic [LVL_W-1:0] lvl_q;

    // Delayed copy of the request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_prev_q <= 1'b0;
        else        req_prev_q <= req_in;
    end

    assign rise = req_in && !req_prev_q;

    // Enable and level registers, loaded on a write to the channel register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            lvl_q <= '0;
        end else if (cfg_wr) begin
            en_q  <= en_val;
            lvl_q <= lvl_val;
        end
    end

    // Channel flag: a request rise sets it, and a write of 1 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (rise)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign flag      = flag_q;
    assign en        = en_q;
    assign level     = lvl_q;
    assign irq_req   = flag_q && en_q;
    assign irq_level = lvl_q;

    a_r5_latch_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> flag_q);
    a_r6_kept_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/cmp_irq_timer.sv
// Top of the compare-match interrupt path. Decodes the register port, holds
// the run bit and the compare value, and joins the counter, the local stage
// and the controller channel. Reads are combinational from addr.
// Assumes: CNT_W >= CH_LVL_LO + LVL_W + 1, so every channel field fits.
module cmp_irq_timer
    import cmpirq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LVL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level
);
    localparam int CH_TRIG_BIT = CH_LVL_LO + LVL_W;

    logic             run_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] count;
    logic             match_evt;
    logic             loc_wr, ch_wr;
    logic             loc_flag, loc_en, loc_req;
    logic             ch_flag, ch_en;
    logic [LVL_W-1:0] ch_lvl;

    // Write decode for the two interrupt registers.
    assign loc_wr = wr_en && (addr == A_LOCAL);
    assign ch_wr  = wr_en && (addr == A_CHAN);

    // Run bit and compare value registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cmp_q <= '0;
        end else if (wr_en) begin
            if (addr == A_RUN) run_q <= wdata[0];
            if (addr == A_CMP) cmp_q <= wdata;
        end
    end

    match_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .cmp_val   (cmp_q),
        .count     (count),
        .match_evt (match_evt)
    );

    local_irq_stage u_loc (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_evt (match_evt),
        .cfg_wr    (loc_wr),
        .en_val    (wdata[LOC_EN_BIT]),
        .flag_clr  (loc_wr && wdata[LOC_FLAG_BIT]),
        .flag      (loc_flag),
        .en        (loc_en),
        .req       (loc_req)
    );

    ctrl_irq_channel #(.LVL_W(LVL_W)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (loc_req),
        .cfg_wr    (ch_wr),
        .en_val    (wdata[CH_EN_BIT]),
        .lvl_val   (wdata[CH_LVL_LO +: LVL_W]),
        .flag_clr  (ch_wr && wdata[CH_FLAG_BIT]),
        .flag      (ch_flag),
        .en        (ch_en),
        .level     (ch_lvl),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );

    // Read mux: assemble the addressed register; unmapped addresses read 0.
    always_comb begin
        rdata = '0;
        case (addr)
            A_RUN:   rdata[0] = run_q;
            A_COUNT: rdata    = count;
            A_CMP:   rdata    = cmp_q;
            A_LOCAL: begin
                rdata[LOC_FLAG_BIT] = loc_flag;
                rdata[LOC_EN_BIT]   = loc_en;
            end
            A_CHAN: begin
                rdata[CH_FLAG_BIT]           = ch_flag;
                rdata[CH_EN_BIT]             = ch_en;
                rdata[CH_LVL_LO +: LVL_W]    = ch_lvl;
                rdata[CH_TRIG_BIT]           = 1'b1;
            end
            default: rdata = '0;
        endcase
    end

    a_r7_level_changes_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_wr |=> $stable(irq_level));
    a_r8_trigger_bit_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CHAN) |-> rdata[CH_TRIG_BIT]);
endmodule

// File: tb/tb_cmp_irq_timer.sv
`timescale 1ns/1ps
module tb_cmp_irq_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_req;
    logic [2:0] irq_level;

    typedef struct {
        bit         is_pins;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    logic  chk_stb = 1'b0;
    int    n_checks = 0;
    int    n_fails = 0;
    bit    done = 0;

    always #2.5 clk = ~clk;

    cmp_irq_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );

    // Monitor: pops the expected item and compares at the falling edge.
    always @(negedge clk) begin
        if (chk_stb && q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = it.is_pins ? {4'b0, irq_req, irq_level} : rdata;
            n_checks++;
            if (act !== it.exp) begin
                n_fails++;
                $display("FAIL %s actual=0x%02h expected=0x%02h", it.tag, act, it.exp);
            end
        end
    end

    // Driver steps: each starts just after a rising edge and lasts one clock.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [7:0] e, input string t);
        item_t it;
        it.is_pins = 0; it.exp = e; it.tag = t;
        addr = a; wr_en = 1'b0;
        q.push_back(it);
        chk_stb = 1'b1;
        @(posedge clk); #1;
        chk_stb = 1'b0;
    endtask

    // Pins are packed as {irq_req, irq_level}.
    task automatic chk_pins(input logic [3:0] e, input string t);
        item_t it;
        it.is_pins = 1; it.exp = {4'b0, e}; it.tag = t;
        q.push_back(it);
        chk_stb = 1'b1;
        @(posedge clk); #1;
        chk_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_reg(3'd0, 8'h00, "R1 reset run");
        chk_reg(3'd1, 8'h00, "R1 reset count");
        chk_reg(3'd2, 8'h00, "R1 reset compare");
        chk_reg(3'd3, 8'h00, "R1 reset local");
        chk_reg(3'd4, 8'h20, "R1 reset channel");
        chk_pins(4'h0, "R1 reset pins");

        // Compare 3, local enable on, then run
        wr(3'd2, 8'd3);
        wr(3'd3, 8'h02);
        wr(3'd0, 8'h01);
        chk_reg(3'd1, 8'd0, "R1 count step 0");
        chk_reg(3'd1, 8'd1, "R1 count step 1");
        chk_reg(3'd1, 8'd2, "R1 count step 2");
        chk_reg(3'd3, 8'h02, "R3 flag clear before match");
        chk_reg(3'd4, 8'h20, "R5 channel not yet set on match edge");
        chk_reg(3'd4, 8'h21, "R5 channel latched with enable 0");
        chk_pins(4'h0, "R7 request gated by enable 0");
        wr(3'd0, 8'h00);
        chk_reg(3'd1, 8'd0, "R2 wrapped at second match");
        chk_reg(3'd3, 8'h03, "R3 enabled flag set");

        // R4: write 0 keeps the flag, write 1 clears it
        wr(3'd3, 8'h02);
        chk_reg(3'd3, 8'h03, "R4 write 0 keeps flag");
        wr(3'd3, 8'h03);
        chk_reg(3'd3, 8'h02, "R4 write 1 clears flag");

        // R9: stopped at equality
        wr(3'd2, 8'd0);
        idle(4);
        chk_reg(3'd3, 8'h02, "R9 no match while stopped");
        chk_reg(3'd1, 8'd0, "R9 count held");
        chk_reg(3'd4, 8'h21, "R6 channel kept after local clear");

        // R6: clear, then no re-set while local request stays high
        wr(3'd4, 8'h01);
        chk_reg(3'd4, 8'h20, "R6 channel clear");
        wr(3'd0, 8'h01);
        wr(3'd0, 8'h00);
        chk_reg(3'd3, 8'h03, "R2 match every cycle at compare 0");
        chk_reg(3'd4, 8'h21, "R5 channel set after rise");
        wr(3'd4, 8'h01);
        idle(3);
        chk_reg(3'd4, 8'h20, "R6 no re-set while request high");

        // R7: enable and level 5
        wr(3'd4, 8'h16);
        chk_reg(3'd4, 8'h36, "R7 enable and level readback");
        chk_pins(4'h5, "R7 level shown, no request");
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h01);
        wr(3'd0, 8'h00);
        chk_pins(4'h5, "R5 request one edge after rise");
        chk_pins(4'hD, "R7 request with flag and enable");
        chk_reg(3'd4, 8'h37, "R5 channel flag readback");

        // R6: set wins over clear on the same edge
        wr(3'd4, 8'h17);
        chk_reg(3'd4, 8'h36, "R6 clear with enable on");
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h01);
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h17);
        chk_reg(3'd4, 8'h37, "R6 set wins over clear");
        chk_pins(4'hD, "R7 request after set-wins");

        // R8: trigger bit is read-only; R7 disabled again
        wr(3'd4, 8'h00);
        chk_reg(3'd4, 8'h21, "R8 trigger bit stays 1");
        chk_pins(4'h0, "R7 request gated after disable");

        // R4: set wins on the local flag
        wr(3'd0, 8'h01);
        wr(3'd3, 8'h03);
        chk_reg(3'd3, 8'h03, "R4 match beats clear");
        wr(3'd0, 8'h00);

        // R3: disabled local stage ignores matches
        wr(3'd3, 8'h01);
        wr(3'd0, 8'h01);
        idle(3);
        wr(3'd0, 8'h00);
        chk_reg(3'd3, 8'h00, "R3 no flag while disabled");
        chk_reg(3'd1, 8'd0, "R2 count at compare 0");

        if (q.size() != 0) begin
            n_fails++;
            $display("FAIL scoreboard actual=%0d expected=0 pending items", q.size());
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule